// File: doc/BRIEF.md
# Low-Power Entry and Exit Sequencer for Mobile DDR Memory

This controller-side block owns the clock-enable line and the command bus of a mobile DDR SDRAM whenever the device moves into or out of a low-power state. A host scheduler asks for power-down, for self refresh, or for a wake. The block looks at per-bank open-row flags and at a clock-stable indication, then produces the exact cycle-by-cycle sequence of CKE levels and commands the memory needs. It returns a ready flag that tells the scheduler when it may issue its own commands again.

For power-down, the block drops CKE at once. It records whether any row was open at that moment, so that active power-down can be told apart from precharge power-down. A built-in duration limit forces an exit before refresh would be missed. For self refresh, the block first closes every open row with a precharge-all and waits the row-precharge time. It then issues the refresh command in the same cycle that CKE goes low. It leaves self refresh only once the clock is stable. Each exit is followed by a window of NOP commands whose length depends on which state is being left.

All timings are counted in clock cycles and set by parameters.

Top module: `lp_entry_exit_seq`

## Requirements
- R1: After reset the block drives CKE high, command code 0 (pass-through), ready high and the active-power-down flag low. Command codes are: 0 pass-through, 1 NOP, 2 DESELECT, 3 PRECHARGE ALL, 4 AUTO REFRESH.
- R2: A power-down request that is sampled while ready is high drives CKE low and ready low on the next cycle. While power-down lasts, the command is DESELECT (code 2).
- R3: The active-power-down flag is high during power-down if any bank was open on the entry edge, and low if all banks were idle.
- R4: A wake request during power-down raises CKE together with NOP (code 1). NOP then stays on the bus for T_XP cycles, after which ready returns high with pass-through.
- R5: If no wake arrives, CKE stays low for exactly PD_MAX cycles in power-down, and the exit of R4 then starts by itself.
- R6: A self-refresh request with any bank open issues PRECHARGE ALL (code 3), then NOP, and issues AUTO REFRESH (code 4) with CKE low exactly T_RP cycles after the precharge.
- R7: A self-refresh request with all banks idle issues AUTO REFRESH with CKE low on the very next cycle.
- R8: In self refresh, CKE stays low and the command is DESELECT for as long as the clock-stable input is low, even when a wake is pending.
- R9: On leaving self refresh, CKE rises with NOP. NOP holds for max(T_XSR, 2) cycles, and ready then returns high.
- R10: A wake that arrives while self-refresh entry is still precharging is remembered. Once AUTO REFRESH has been issued, the exit begins on the next cycle if the clock is stable.
- R11: A wake sampled while ready is high, or during an exit window, has no effect. A self-refresh request takes priority over a simultaneous power-down request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pd_req_i | input | 1 | Request power-down (sampled while ready) |
| sr_req_i | input | 1 | Request self refresh (sampled while ready) |
| wake_req_i | input | 1 | Request exit from the current low-power state |
| bank_open_i | input | NBANK | One bit per bank, high when a row is open |
| clk_stable_i | input | 1 | Clock is stable; self-refresh exit allowed |
| cke_o | output | 1 | Clock-enable to the memory |
| cmd_o | output | 3 | Command code (0 pass, 1 NOP, 2 DESELECT, 3 PRECHARGE ALL, 4 AUTO REFRESH) |
| ready_o | output | 1 | Scheduler may issue normal commands |
| pd_active_o | output | 1 | Current power-down was entered with a row open |

## Verification
The bench targets the window boundaries. If a design counted T_RP, T_XP or the self-refresh window off by one, AUTO REFRESH or the return of ready would appear a cycle early or late. Tests also cover a wake that arrives during precharge, where a design could drop the wake and sleep for ever, and a wake that arrives while the clock is unstable, where a design could raise CKE too soon. A forced power-down with no wake at all checks the maximum-duration limit. Another case sends simultaneous power-down and self-refresh requests, which would expose the wrong priority.

// File: rtl/lpseq_pkg.sv
package lpseq_pkg;

    typedef enum logic [2:0] {
        CMD_PASS   = 3'd0,
        CMD_NOP    = 3'd1,
        CMD_DESEL  = 3'd2,
        CMD_PREALL = 3'd3,
        CMD_AREF   = 3'd4
    } lp_cmd_e;

    typedef enum logic [2:0] {
        ST_IDLE    = 3'd0,
        ST_PRECH   = 3'd1,
        ST_SR      = 3'd2,
        ST_SR_EXIT = 3'd3,
        ST_PD      = 3'd4,
        ST_PD_EXIT = 3'd5
    } lp_state_e;

    typedef struct packed {
        lp_state_e state;
        logic      cke;
        lp_cmd_e   cmd;
        logic      ready;
        logic      pd_active;
        logic      wake_pend;
    } lp_regs_t;

endpackage

// File: rtl/lpseq_timer.sv
module lpseq_timer #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load_i,
    input  logic [W-1:0] value_i,
    output logic         last_o
);

    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load_i) begin
            cnt_d = value_i;
        end else if (cnt_q != '0) begin
            cnt_d = cnt_q - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign last_o = (cnt_q == W'(1));

endmodule

// File: rtl/lpseq_bank_scan.sv
module lpseq_bank_scan #(
    parameter int NBANK = 4
) (
    input  logic [NBANK-1:0] bank_open_i,
    output logic             any_open_o
);

    logic [NBANK:0] chain;

    assign chain[0] = 1'b0;

    for (genvar b = 0; b < NBANK; b++) begin : g_scan
        assign chain[b+1] = chain[b] | bank_open_i[b];
    end

    assign any_open_o = chain[NBANK];

endmodule

// File: rtl/lp_entry_exit_seq.sv
module lp_entry_exit_seq
    import lpseq_pkg::*;
#(
    parameter int NBANK  = 4,
    parameter int T_RP   = 3,
    parameter int T_XP   = 2,
    parameter int T_XSR  = 20,
    parameter int PD_MAX = 1000
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pd_req_i,
    input  logic             sr_req_i,
    input  logic             wake_req_i,
    input  logic [NBANK-1:0] bank_open_i,
    input  logic             clk_stable_i,
    output logic             cke_o,
    output logic [2:0]       cmd_o,
    output logic             ready_o,
    output logic             pd_active_o
);

    localparam int T_XSR_EFF = (T_XSR < 2) ? 2 : T_XSR;
    localparam int MAX_A     = (T_RP > T_XP) ? T_RP : T_XP;
    localparam int MAX_B     = (T_XSR_EFF > PD_MAX) ? T_XSR_EFF : PD_MAX;
    localparam int MAX_T     = (MAX_A > MAX_B) ? MAX_A : MAX_B;
    localparam int TW        = $clog2(MAX_T + 1);

    lp_regs_t        r_d, r_q;
    logic            any_open;
    logic            t_load;
    logic [TW-1:0]   t_val;
    logic            t_last;
    logic            wake_seen;

    lpseq_bank_scan #(.NBANK(NBANK)) i_scan (
        .bank_open_i (bank_open_i),
        .any_open_o  (any_open)
    );

    lpseq_timer #(.W(TW)) i_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .load_i  (t_load),
        .value_i (t_val),
        .last_o  (t_last)
    );

    assign wake_seen = r_q.wake_pend | wake_req_i;

    always_comb begin
        r_d    = r_q;
        t_load = 1'b0;
        t_val  = '0;
        unique case (r_q.state)
            ST_IDLE: begin
                r_d.cmd       = CMD_PASS;
                r_d.wake_pend = 1'b0;
                if (sr_req_i) begin
                    r_d.ready = 1'b0;
                    if (any_open) begin
                        r_d.state = ST_PRECH;
                        r_d.cmd   = CMD_PREALL;
                        t_load    = 1'b1;
                        t_val     = TW'(T_RP);
                    end else begin
                        r_d.state = ST_SR;
                        r_d.cke   = 1'b0;
                        r_d.cmd   = CMD_AREF;
                    end
                end else if (pd_req_i) begin
                    r_d.state     = ST_PD;
                    r_d.cke       = 1'b0;
                    r_d.cmd       = CMD_DESEL;
                    r_d.ready     = 1'b0;
                    r_d.pd_active = any_open;
                    t_load        = 1'b1;
                    t_val         = TW'(PD_MAX);
                end
            end
            ST_PRECH: begin
                r_d.cmd = CMD_NOP;
                if (wake_req_i) begin
                    r_d.wake_pend = 1'b1;
                end
                if (t_last) begin
                    r_d.state = ST_SR;
                    r_d.cke   = 1'b0;
                    r_d.cmd   = CMD_AREF;
                end
            end
            ST_SR: begin
                r_d.cmd = CMD_DESEL;
                if (wake_req_i) begin
                    r_d.wake_pend = 1'b1;
                end
                if (wake_seen && clk_stable_i) begin
                    r_d.state     = ST_SR_EXIT;
                    r_d.cke       = 1'b1;
                    r_d.cmd       = CMD_NOP;
                    r_d.wake_pend = 1'b0;
                    t_load        = 1'b1;
                    t_val         = TW'(T_XSR_EFF);
                end
            end
            ST_SR_EXIT, ST_PD_EXIT: begin
                r_d.cmd = CMD_NOP;
                if (t_last) begin
                    r_d.state = ST_IDLE;
                    r_d.ready = 1'b1;
                    r_d.cmd   = CMD_PASS;
                end
            end
            ST_PD: begin
                r_d.cmd = CMD_DESEL;
                if (wake_req_i || t_last) begin
                    r_d.state     = ST_PD_EXIT;
                    r_d.cke       = 1'b1;
                    r_d.cmd       = CMD_NOP;
                    r_d.pd_active = 1'b0;
                    t_load        = 1'b1;
                    t_val         = TW'(T_XP);
                end
            end
            default: begin
                r_d.state = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.state     <= ST_IDLE;
            r_q.cke       <= 1'b1;
            r_q.cmd       <= CMD_PASS;
            r_q.ready     <= 1'b1;
            r_q.pd_active <= 1'b0;
            r_q.wake_pend <= 1'b0;
        end else begin
            r_q <= r_d;
        end
    end

    assign cke_o       = r_q.cke;
    assign cmd_o       = r_q.cmd;
    assign ready_o     = r_q.ready;
    assign pd_active_o = r_q.pd_active;

    // R2: while CKE is low the scheduler never sees ready
    a_r2_ready_low_in_lp: assert property (@(posedge clk) disable iff (!rst_n)
        !cke_o |-> !ready_o);

    // R4 / R9: every CKE rise carries a NOP
    a_r4_rise_with_nop: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cke_o) |-> (cmd_o == CMD_NOP));

    // R6 / R7: refresh command only with CKE low
    a_r7_aref_cke_low: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_o == CMD_AREF) |-> !cke_o);

    // R6: precharge-all only as the first step out of ready
    a_r6_preall_from_ready: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_o == CMD_PREALL) |-> $past(ready_o));

    // R8: self-refresh exit only with a stable clock
    a_r8_exit_needs_clock: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(cke_o) && $past(r_q.state) == ST_SR) |-> $past(clk_stable_i));

    // R9: ready returns only after a NOP window with CKE high
    a_r9_ready_after_nop: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ready_o) |-> ($past(cmd_o) == CMD_NOP && $past(cke_o)));

endmodule

// File: tb/test_lp_entry_exit_seq.sv
module test_lp_entry_exit_seq;

    localparam int NB     = 4;
    localparam int TRP    = 3;
    localparam int TXP    = 2;
    localparam int TXSR   = 20;
    localparam int PDMAX  = 1000;
    localparam int TXSR_E = (TXSR < 2) ? 2 : TXSR;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          pd_req = 1'b0, sr_req = 1'b0, wake = 1'b0, stable = 1'b1;
    logic [NB-1:0] banks = '0;
    logic          cke, ready, pdact;
    logic [2:0]    cmd;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;
    string cur_req = "R1";

    always #10 clk = ~clk;

    lp_entry_exit_seq #(.NBANK(NB), .T_RP(TRP), .T_XP(TXP), .T_XSR(TXSR), .PD_MAX(PDMAX)) i_lp_entry_exit_seq (
        .clk(clk), .rst_n(rst_n), .pd_req_i(pd_req), .sr_req_i(sr_req),
        .wake_req_i(wake), .bank_open_i(banks), .clk_stable_i(stable),
        .cke_o(cke), .cmd_o(cmd), .ready_o(ready), .pd_active_o(pdact));

    // behavioural reference: phase plus absolute deadlines
    int phase, cyc, dl;
    int m_cke, m_cmd, m_ready, m_pdact, m_pend;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            phase = 0; cyc = 0; dl = 0;
            m_cke = 1; m_cmd = 0; m_ready = 1; m_pdact = 0; m_pend = 0;
        end else begin
            cyc = cyc + 1;
            if (phase == 0) begin
                m_cmd = 0;
                if (sr_req) begin
                    m_ready = 0;
                    if (banks != 0) begin phase = 1; m_cmd = 3; dl = cyc + TRP; end
                    else begin phase = 2; m_cke = 0; m_cmd = 4; end
                end else if (pd_req) begin
                    phase = 4; m_cke = 0; m_cmd = 2; m_ready = 0;
                    m_pdact = (banks != 0); dl = cyc + PDMAX;
                end
            end else if (phase == 1) begin
                m_cmd = 1;
                if (wake) m_pend = 1;
                if (cyc == dl) begin phase = 2; m_cke = 0; m_cmd = 4; end
            end else if (phase == 2) begin
                m_cmd = 2;
                if (wake) m_pend = 1;
                if (m_pend == 1 && stable) begin
                    phase = 3; m_cke = 1; m_cmd = 1; m_pend = 0; dl = cyc + TXSR_E;
                end
            end else if (phase == 4) begin
                m_cmd = 2;
                if (wake || cyc == dl) begin
                    phase = 5; m_cke = 1; m_cmd = 1; m_pdact = 0; dl = cyc + TXP;
                end
            end else begin
                m_cmd = 1;
                if (cyc == dl) begin phase = 0; m_ready = 1; m_cmd = 0; end
            end
        end
    end

    task automatic chk(string rq, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s actual=%0d expected=%0d", rq, what, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (rst_n) begin
            cycles++;
            chk(cur_req, "cke", int'(cke), m_cke);
            chk(cur_req, "cmd", int'(cmd), m_cmd);
            chk(cur_req, "ready", int'(ready), m_ready);
            chk(cur_req, "pd_active", int'(pdact), m_pdact);
            if (cycles > 150000) begin
                fails++;
                $display("FAIL watchdog actual=%0d expected=0", cycles);
                $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
                $finish;
            end
        end
    end

    task automatic tick(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse_pd();
        pd_req = 1'b1; tick(1); pd_req = 1'b0;
    endtask

    task automatic pulse_sr();
        sr_req = 1'b1; tick(1); sr_req = 1'b0;
    endtask

    task automatic pulse_wake();
        wake = 1'b1; tick(1); wake = 1'b0;
    endtask

    initial begin
        tick(2);
        rst_n = 1'b1;
        tick(1);
        cur_req = "R1";
        chk("R1", "reset cke", int'(cke), 1);
        chk("R1", "reset cmd", int'(cmd), 0);
        chk("R1", "reset ready", int'(ready), 1);
        chk("R1", "reset pd_active", int'(pdact), 0);

        // precharge power-down, woken
        cur_req = "R2"; banks = '0;
        pulse_pd();
        chk("R2", "cke after pd", int'(cke), 0);
        chk("R2", "ready after pd", int'(ready), 0);
        chk("R3", "precharge pd flag", int'(pdact), 0);
        tick(4);
        chk("R2", "deselect in pd", int'(cmd), 2);
        cur_req = "R4";
        pulse_wake();
        chk("R4", "cke on wake", int'(cke), 1);
        chk("R4", "nop on wake", int'(cmd), 1);
        tick(TXP - 1);
        chk("R4", "ready still low", int'(ready), 0);
        tick(1);
        chk("R4", "ready after txp", int'(ready), 1);
        tick(3);

        // active power-down
        cur_req = "R3"; banks = 4'b0100;
        pulse_pd();
        chk("R3", "active pd flag", int'(pdact), 1);
        banks = '0;
        tick(5);
        chk("R3", "flag held", int'(pdact), 1);
        pulse_wake();
        tick(TXP + 3);

        // forced exit at max duration
        cur_req = "R5";
        pulse_pd();
        tick(PDMAX - 1);
        chk("R5", "cke low before limit", int'(cke), 0);
        tick(1);
        chk("R5", "cke high at limit", int'(cke), 1);
        tick(TXP + 3);

        // self refresh with open bank
        cur_req = "R6"; banks = 4'b1001;
        pulse_sr();
        chk("R6", "precharge all", int'(cmd), 3);
        banks = '0;
        tick(TRP - 1);
        chk("R6", "nop before aref", int'(cmd), 1);
        tick(1);
        chk("R6", "aref", int'(cmd), 4);
        chk("R6", "cke low with aref", int'(cke), 0);
        tick(8);
        cur_req = "R9";
        pulse_wake();
        chk("R9", "cke rises", int'(cke), 1);
        tick(TXSR_E - 1);
        chk("R9", "still nop", int'(cmd), 1);
        tick(1);
        chk("R9", "ready after txsr", int'(ready), 1);
        tick(3);

        // idle banks, unstable clock
        cur_req = "R7";
        pulse_sr();
        chk("R7", "direct aref", int'(cmd), 4);
        cur_req = "R8"; stable = 1'b0;
        tick(3);
        pulse_wake();
        tick(10);
        chk("R8", "cke held low", int'(cke), 0);
        chk("R8", "deselect held", int'(cmd), 2);
        stable = 1'b1;
        tick(1);
        chk("R8", "exit once stable", int'(cke), 1);
        tick(TXSR_E + 3);

        // wake during precharge
        cur_req = "R10"; banks = 4'b0010;
        pulse_sr();
        banks = '0;
        pulse_wake();
        tick(TRP - 1);
        chk("R10", "aref reached", int'(cmd), 4);
        tick(1);
        chk("R10", "exit follows", int'(cke), 1);
        tick(TXSR_E + 3);

        // ignored wakes and priority
        cur_req = "R11";
        pulse_wake();
        chk("R11", "idle wake ignored cke", int'(cke), 1);
        chk("R11", "idle wake ignored ready", int'(ready), 1);
        pd_req = 1'b1; sr_req = 1'b1; tick(1); pd_req = 1'b0; sr_req = 1'b0;
        chk("R11", "sr wins", int'(cmd), 4);
        tick(2);
        pulse_wake();
        pulse_wake();
        chk("R11", "wake in window no effect", int'(cmd), 1);
        tick(TXSR_E + 2);
        chk("R11", "no re-entry", int'(cke), 1);
        pulse_pd();
        pulse_wake();
        pulse_wake();
        tick(TXP + 2);
        chk("R11", "back to ready", int'(ready), 1);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule